// File: doc/BRIEF.md
# Double-Rate Input Capture with Selectable Alignment

This block samples one serial data input on the rising edges of two complementary clocks, `clk_a` and `clk_b`. The clocks are nominally 180 degrees apart at a 50% duty cycle. The bit present before a `clk_a` edge is captured for `dout_a`. The bit present before a `clk_b` edge is captured for `dout_b`. Each edge has only half a clock period of valid data, so a stream with one new bit per half-cycle is split into two parallel half-rate lanes.

A static parameter sets how the two lanes are presented:

- **Split mode.** Each output stays in the clock domain that captured it.
- **Aligned modes.** The sample taken on one clock is registered a second time on the rising edge of the other clock. Both outputs then change together on a single clock. Logic downstream reads one clock domain and needs no half-cycle timing paths of its own. The retimed lane costs one extra half-cycle of latency.

A clock enable freezes every register. A reset and a preset force known values, and a parameter makes them either synchronous or asynchronous.

Top module: `ddr_in_capture`

## Requirements
- R1: Parameter `ALIGN_MODE` selects one of three modes: ALIGN_SPLIT = 0, ALIGN_ON_A = 1 and ALIGN_ON_B = 2. The routing of each mode is given in R2 to R4.
- R2: In ALIGN_SPLIT, `dout_a` takes the value `din` had at each rising `clk_a` edge and changes only on `clk_a`. `dout_b` takes the value `din` had at each rising `clk_b` edge and changes only on `clk_b`.
- R3: In ALIGN_ON_A, both outputs change only on rising `clk_a`. After a `clk_a` edge, `dout_a` holds `din` sampled at that edge. `dout_b` holds `din` sampled at the preceding enabled `clk_b` edge.
- R4: In ALIGN_ON_B, both outputs change only on rising `clk_b`. After a `clk_b` edge, `dout_b` holds `din` sampled at that edge. `dout_a` holds `din` sampled at the preceding enabled `clk_a` edge.
- R5: When `clk_en` is low at an edge, every register clocked by that edge keeps its value, so the outputs it drives do not change.
- R6: `rst` forces every register to `INIT_VAL` (default all zeros). It wins over `preset` and over capture, so both outputs read `INIT_VAL` while it is held.
- R7: `preset` (with `rst` low) forces every register to all ones, overriding capture and `clk_en`.
- R8: With `SYNC_CTRL` = 1, `rst` and `preset` act only at rising edges of each register's own clock. With `SYNC_CTRL` = 0, they change the outputs at once, without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | First capture clock (rising edge) |
| clk_b | input | 1 | Second capture clock, complement of clk_a |
| clk_en | input | 1 | Clock enable for all registers |
| rst | input | 1 | Reset to INIT_VAL, highest priority |
| preset | input | 1 | Preset to all ones |
| din | input | DATA_W | Serial data input, one value per half-cycle |
| dout_a | output | DATA_W | Lane captured on clk_a |
| dout_b | output | DATA_W | Lane captured on clk_b |

## Verification
A corrupted capture register shows at its own output one edge later, half a period after the bad sample. A corrupted retiming register shows on the next edge of the aligning clock. In the aligned modes, a retiming register that wrongly listens to the other clock makes an output move on the wrong edge. The bench catches this within one half-cycle because it compares both outputs after every edge of either clock. Lanes that are swapped or routed wrongly show up as even-phase bits on the odd lane at the first edge where a stream bit differs from its neighbour.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;

    // Output alignment: both lanes in own domains, or both on one clock.
    typedef enum logic [1:0] {
        ALIGN_SPLIT = 2'd0,
        ALIGN_ON_A  = 2'd1,
        ALIGN_ON_B  = 2'd2
    } align_mode_e;

endpackage

// File: rtl/ddr_cap_lane.sv
// One clock domain of the capture stage: a capture register and an
// optional retiming register fed from the opposite lane.
module ddr_cap_lane #(
    parameter int              W         = 1,
    parameter bit              SYNC_CTRL = 1'b1,
    parameter bit              RETIME    = 1'b0,
    parameter logic [W-1:0]    INIT_VAL  = '0
) (
    input  logic         clk,
    input  logic         clk_en,
    input  logic         rst,
    input  logic         preset,
    input  logic [W-1:0] din,
    input  logic [W-1:0] far_in,
    output logic [W-1:0] cap_o,
    output logic [W-1:0] rt_o
);

    typedef struct packed {
        logic [W-1:0] cap;
        logic [W-1:0] rt;
    } lane_t;

    localparam logic [W-1:0] ONES    = '1;
    localparam lane_t        CLR_VAL = {INIT_VAL, INIT_VAL};
    localparam lane_t        SET_VAL = {ONES, ONES};

    lane_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (SYNC_CTRL && rst) begin
            st_d = CLR_VAL;
        end else if (SYNC_CTRL && preset) begin
            st_d = SET_VAL;
        end else if (clk_en) begin
            st_d.cap = din;
            st_d.rt  = RETIME ? far_in : st_q.rt;
        end
    end

    generate
        if (SYNC_CTRL) begin : g_sync
            always_ff @(posedge clk) begin
                st_q <= st_d;
            end
        end else begin : g_async
            always_ff @(posedge clk or posedge rst or posedge preset) begin
                if (rst) begin
                    st_q <= CLR_VAL;
                end else if (preset) begin
                    st_q <= SET_VAL;
                end else begin
                    st_q <= st_d;
                end
            end
        end
    endgenerate

    assign cap_o = st_q.cap;
    assign rt_o  = st_q.rt;

endmodule

// File: rtl/ddr_in_capture.sv
module ddr_in_capture
    import ddr_cap_pkg::*;
#(
    parameter align_mode_e          ALIGN_MODE = ALIGN_SPLIT,
    parameter int                   DATA_W     = 1,
    parameter bit                   SYNC_CTRL  = 1'b1,
    parameter logic [DATA_W-1:0]    INIT_VAL   = '0
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              clk_en,
    input  logic              rst,
    input  logic              preset,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout_a,
    output logic [DATA_W-1:0] dout_b
);

    localparam bit RETIME_A = (ALIGN_MODE == ALIGN_ON_A);
    localparam bit RETIME_B = (ALIGN_MODE == ALIGN_ON_B);

    logic [DATA_W-1:0] cap_a, rt_a, cap_b, rt_b;

    // Lane A: captures on clk_a, retimes lane B's sample when aligning on A.
    ddr_cap_lane #(
        .W(DATA_W), .SYNC_CTRL(SYNC_CTRL), .RETIME(RETIME_A), .INIT_VAL(INIT_VAL)
    ) u_lane_a (
        .clk(clk_a), .clk_en(clk_en), .rst(rst), .preset(preset),
        .din(din), .far_in(cap_b), .cap_o(cap_a), .rt_o(rt_a)
    );

    // Lane B: captures on clk_b, retimes lane A's sample when aligning on B.
    ddr_cap_lane #(
        .W(DATA_W), .SYNC_CTRL(SYNC_CTRL), .RETIME(RETIME_B), .INIT_VAL(INIT_VAL)
    ) u_lane_b (
        .clk(clk_b), .clk_en(clk_en), .rst(rst), .preset(preset),
        .din(din), .far_in(cap_a), .cap_o(cap_b), .rt_o(rt_b)
    );

    assign dout_a = RETIME_B ? rt_b : cap_a;
    assign dout_b = RETIME_A ? rt_a : cap_b;

endmodule

// File: rtl/ddr_in_capture_chk.sv
module ddr_in_capture_chk
    import ddr_cap_pkg::*;
#(
    parameter align_mode_e     MODE = ALIGN_SPLIT,
    parameter int              W    = 1,
    parameter logic [W-1:0]    INIT = '0
) (
    input logic         clk_a,
    input logic         clk_b,
    input logic         clk_en,
    input logic         rst,
    input logic         preset,
    input logic [W-1:0] din,
    input logic [W-1:0] dout_a,
    input logic [W-1:0] dout_b
);

    localparam logic [W-1:0] ONES = '1;

    logic [1:0] rst_run = '0;
    logic [1:0] set_run = '0;

    always_ff @(posedge clk_a) begin
        rst_run <= rst ? ((rst_run == 2'd3) ? rst_run : rst_run + 2'd1) : 2'd0;
        set_run <= (preset && !rst) ? ((set_run == 2'd3) ? set_run : set_run + 2'd1) : 2'd0;
    end

    AST_RESET_STATE: assert property (@(posedge clk_a)
        (rst && rst_run >= 2'd2) |-> (dout_a == INIT && dout_b == INIT)); // R6

    AST_PRESET_STATE: assert property (@(posedge clk_a) disable iff (rst)
        (preset && set_run >= 2'd2) |-> (dout_a == ONES && dout_b == ONES)); // R7

    generate
        if (MODE != ALIGN_ON_B) begin : g_a_direct
            AST_A_LANE_CAPTURE: assert property (@(posedge clk_a) disable iff (rst || preset)
                ($past(clk_en) && !$past(rst) && !$past(preset)) |-> dout_a == $past(din)); // R2
            AST_CE_HOLD_A: assert property (@(posedge clk_a) disable iff (rst || preset)
                (!$past(clk_en) && !$past(rst) && !$past(preset)) |-> $stable(dout_a)); // R5
        end
        if (MODE != ALIGN_ON_A) begin : g_b_direct
            AST_B_LANE_CAPTURE: assert property (@(posedge clk_b) disable iff (rst || preset)
                ($past(clk_en) && !$past(rst) && !$past(preset)) |-> dout_b == $past(din)); // R2
            AST_CE_HOLD_B: assert property (@(posedge clk_b) disable iff (rst || preset)
                (!$past(clk_en) && !$past(rst) && !$past(preset)) |-> $stable(dout_b)); // R5
        end
        if (MODE == ALIGN_ON_A) begin : g_on_a
            logic [W-1:0] b_shadow;
            always_ff @(posedge clk_b) begin
                b_shadow <= rst ? INIT : preset ? ONES : clk_en ? din : b_shadow;
            end
            AST_RETIME_ON_A: assert property (@(posedge clk_a) disable iff (rst || preset)
                ($past(clk_en) && !$past(rst) && !$past(preset)) |-> dout_b == $past(b_shadow)); // R3
        end
        if (MODE == ALIGN_ON_B) begin : g_on_b
            logic [W-1:0] a_shadow;
            always_ff @(posedge clk_a) begin
                a_shadow <= rst ? INIT : preset ? ONES : clk_en ? din : a_shadow;
            end
            AST_RETIME_ON_B: assert property (@(posedge clk_b) disable iff (rst || preset)
                ($past(clk_en) && !$past(rst) && !$past(preset)) |-> dout_a == $past(a_shadow)); // R4
        end
    endgenerate

endmodule

bind ddr_in_capture ddr_in_capture_chk #(
    .MODE(ALIGN_MODE), .W(DATA_W), .INIT(INIT_VAL)
) u_chk (
    .clk_a(clk_a), .clk_b(clk_b), .clk_en(clk_en), .rst(rst), .preset(preset),
    .din(din), .dout_a(dout_a), .dout_b(dout_b)
);

// File: tb/tb_ddr_in_capture.sv
module tb_ddr_in_capture;
    import ddr_cap_pkg::*;

    localparam logic [31:0] PAT = 32'hB38F_1C6D;

    logic clk = 1'b0;
    logic clk_a, clk_b;
    logic rst = 1'b1, preset = 1'b0, clk_en = 1'b0;
    logic rst_x = 1'b1, set_x = 1'b0;
    logic [0:0] din = 1'b0;
    logic [0:0] sa_a, sa_b, aa_a, aa_b, ab_a, ab_b, xa_a, xa_b;

    always #10 clk = ~clk;   // 50 MHz
    assign clk_a = clk;
    assign clk_b = ~clk;

    ddr_in_capture #(.ALIGN_MODE(ALIGN_SPLIT)) dut (
        .clk_a(clk_a), .clk_b(clk_b), .clk_en(clk_en), .rst(rst), .preset(preset),
        .din(din), .dout_a(sa_a), .dout_b(sa_b));
    ddr_in_capture #(.ALIGN_MODE(ALIGN_ON_A)) dut_on_a (
        .clk_a(clk_a), .clk_b(clk_b), .clk_en(clk_en), .rst(rst), .preset(preset),
        .din(din), .dout_a(aa_a), .dout_b(aa_b));
    ddr_in_capture #(.ALIGN_MODE(ALIGN_ON_B)) dut_on_b (
        .clk_a(clk_a), .clk_b(clk_b), .clk_en(clk_en), .rst(rst), .preset(preset),
        .din(din), .dout_a(ab_a), .dout_b(ab_b));
    ddr_in_capture #(.ALIGN_MODE(ALIGN_ON_A), .SYNC_CTRL(1'b0)) dut_async (
        .clk_a(clk_a), .clk_b(clk_b), .clk_en(clk_en), .rst(rst_x), .preset(set_x),
        .din(din), .dout_a(xa_a), .dout_b(xa_b));

    typedef struct {
        logic [5:0] exp;
        string      tag;
        bit         chk;
    } item_t;

    item_t sbq[$];
    int    vectors = 0;
    int    fails   = 0;
    bit    finished = 1'b0;

    // Requirement-level model: capture A/B and retimed-on-A/B values.
    logic m_a = 1'b0, m_b = 1'b0, r_a = 1'b0, r_b = 1'b0;

    task automatic check1(input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    // Driver: sets inputs for the coming edge and queues expected outputs.
    task automatic step(input logic d, input logic ce, input logic r,
                        input logic s, input string tag, input bit chk = 1'b1);
        item_t it;
        @(clk);
        #2;
        din = d; clk_en = ce; rst = r; preset = s;
        if (clk == 1'b0) begin            // coming edge is rising clk_a
            if (r)       begin m_a = 1'b0; r_a = 1'b0; end
            else if (s)  begin m_a = 1'b1; r_a = 1'b1; end
            else if (ce) begin r_a = m_b;  m_a = d;    end
        end else begin                    // coming edge is rising clk_b
            if (r)       begin m_b = 1'b0; r_b = 1'b0; end
            else if (s)  begin m_b = 1'b1; r_b = 1'b1; end
            else if (ce) begin r_b = m_a;  m_b = d;    end
        end
        it.exp = {m_a, m_b, m_a, r_a, r_b, m_b};
        it.tag = tag;
        it.chk = chk;
        sbq.push_back(it);
    endtask

    // Monitor: after every edge of either clock, compare all three modes.
    initial begin
        forever begin
            @(clk);
            #1;
            if (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                if (it.chk) begin
                    check1({"R1 R2 split dout_a ", it.tag}, sa_a, it.exp[5]);
                    check1({"R1 R2 split dout_b ", it.tag}, sa_b, it.exp[4]);
                    check1({"R1 R3 on_a dout_a ", it.tag},  aa_a, it.exp[3]);
                    check1({"R1 R3 on_a dout_b ", it.tag},  aa_b, it.exp[2]);
                    check1({"R1 R4 on_b dout_a ", it.tag},  ab_a, it.exp[1]);
                    check1({"R1 R4 on_b dout_b ", it.tag},  ab_b, it.exp[0]);
                end
            end
        end
    end

    initial begin
        #4_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // Reset phase: first edges unchecked until both domains have seen rst.
        step(1'b0, 1'b0, 1'b1, 1'b0, "R6 reset", 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0, "R6 reset", 1'b0);
        step(1'b1, 1'b1, 1'b1, 1'b0, "R6 reset state");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R6 reset state");
        rst_x = 1'b0;

        // Distinct bit per half-cycle.
        for (int k = 0; k < 24; k++) step(PAT[k], 1'b1, 1'b0, 1'b0, "R2 R3 R4 stream");

        // Enable low with changing data: everything holds.
        for (int k = 0; k < 6; k++) step(logic'(k[0]), 1'b0, 1'b0, 1'b0, "R5 hold");
        for (int k = 24; k < 30; k++) step(PAT[k], 1'b1, 1'b0, 1'b0, "R5 resume");

        // Preset over capture, then reset over preset.
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b0, 1'b1, "R7 preset");
        for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b1, 1'b1, "R6 priority");

        // Alternating patterns: even phase ones, then odd phase ones.
        for (int k = 0; k < 8; k++) step(~logic'(k[0]), 1'b1, 1'b0, 1'b0, "R2 R3 R4 even-ones");
        for (int k = 0; k < 8; k++) step(logic'(k[0]), 1'b1, 1'b0, 1'b0, "R2 R3 R4 odd-ones");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R5 hold");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R5 hold");

        // Asynchronous control instance: effect between clock edges.
        @(posedge clk);
        #5;
        set_x = 1'b1;
        #1;
        check1("R8 R7 async preset dout_a", xa_a, 1'b1);
        check1("R8 R7 async preset dout_b", xa_b, 1'b1);
        #10;
        rst_x = 1'b1;
        #1;
        check1("R8 R6 async reset over preset dout_a", xa_a, 1'b0);
        check1("R8 R6 async reset over preset dout_b", xa_b, 1'b0);
        #10;
        #5;
        rst_x = 1'b0;
        set_x = 1'b0;
        #1;
        check1("R8 R6 async release dout_a", xa_a, 1'b0);
        check1("R8 R6 async release dout_b", xa_b, 1'b0);

        // Synchronous instances untouched by the async window (enable low).
        for (int k = 0; k < 10; k++) step(PAT[k+5], 1'b1, 1'b0, 1'b0, "R2 R3 R4 restart");
        @(clk);
        @(clk);
        #3;

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule